// File: doc/BRIEF.md
# Parallel Port Wake Sequence Detector

This block sits on the device side of an adapter that bridges a host parallel port to a disk. It watches the eight host data lines and the four control lines. It waits for a fixed seven-byte unlock pattern followed by a command byte. Once a valid command has been captured, the host strobes the control lines from 4 up to 5 and back to 4, and the command takes effect at that point. The block has two results: an adapter-enabled level, and a one-cycle pulse that resets the protocol engine downstream.

While the pattern is in progress, the block returns a 12-bit chip identifier (0xB5F) one nibble at a time on the upper status nibble. A host probe can use this to find out whether the adapter is present. Both input buses are asynchronous to the block clock, so each passes through a two-flop synchroniser. A data byte counts as one step each time its value changes, so a value that is held counts only once.

Top module: `pp_wake_detect`

## Requirements
- R1: After reset, `enabled_o` is 0, `eng_rst_o` is 0 and `stat_o` is 0.
- R2: The data sequence FE, AA, 55, 00, FF, 87, 78, 20 (hex) followed by control 5 and then control 4 sets `enabled_o` to 1. In the same step, `eng_rst_o` is high for exactly one clock cycle.
- R3: The same sequence with command 30 (hex) clears `enabled_o` and gives no `eng_rst_o` pulse.
- R4: Command 00 gives one `eng_rst_o` pulse and leaves `enabled_o` unchanged.
- R5: A captured command acts only when control goes to 5 and then to 4. A command byte other than 20, 30 or 00 restarts the matcher, and a later strobe then has no effect.
- R6: `stat_o` carries identifier bits 11:8 (B) while the last matched byte is FF, and bits 7:4 (5) while the last matched byte is 87. It carries bits 3:0 (F) from the moment control reaches 5 after a valid command until the command acts or is aborted. In every other state it is 0, including the wait for the strobe after the command byte.
- R7: A byte that does not match the expected step restarts the matcher. If that byte is FE, matching restarts at the second step.
- R8: A data value that is held for any number of cycles advances the matcher once.
- R9: A data change after the command byte aborts the pending command. A data change in the same cycle as control returning to 4 also aborts, and the abort wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pdata_i | input | 8 | Host data lines, asynchronous |
| pctl_i | input | 4 | Host control lines, asynchronous |
| stat_o | output | 4 | Identifier nibble, driven onto status bits 7:4 |
| enabled_o | output | 1 | Adapter enabled |
| eng_rst_o | output | 1 | One-cycle protocol engine reset |

## Verification
Two events can meet in one cycle: the control lines returning to 4, which would execute the pending command, and a change on the data lines, which aborts it. The bench provokes this by changing both buses on the same clock edge while a command waits with control at 5. Both buses pass through synchronisers of equal depth, so the two events reach the matcher in the same cycle. The bench judges the outcome by whether `enabled_o` and the count of `eng_rst_o` pulses stay unchanged and `stat_o` falls to 0.

// File: rtl/pp_wake_pkg.sv
package pp_wake_pkg;
  typedef enum logic [1:0] {ST_HUNT, ST_ARMED, ST_STB} wake_st_e;

  localparam int PAT_LEN = 7;
  localparam int IDX_W   = $clog2(PAT_LEN + 1);
  localparam int IDX_HI  = 5;  // last match was FF
  localparam int IDX_MID = 6;  // last match was 87

  localparam logic [7:0] CMD_ON    = 8'h20;
  localparam logic [7:0] CMD_OFF   = 8'h30;
  localparam logic [7:0] CMD_PROBE = 8'h00;
  localparam logic [3:0] CTL_REST  = 4'h4;
  localparam logic [3:0] CTL_STB   = 4'h5;

  function automatic logic [7:0] pat_byte(input logic [IDX_W-1:0] i);
    case (i)
      3'd0:    pat_byte = 8'hFE;
      3'd1:    pat_byte = 8'hAA;
      3'd2:    pat_byte = 8'h55;
      3'd3:    pat_byte = 8'h00;
      3'd4:    pat_byte = 8'hFF;
      3'd5:    pat_byte = 8'h87;
      default: pat_byte = 8'h78;
    endcase
  endfunction
endpackage

// File: rtl/pp_sync.sv
module pp_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2  // must be >= 2
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [STAGES-1:0][W-1:0] stg;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) stg <= '0;
    else         stg <= {stg[STAGES-2:0], d_i};
  end

  assign q_o = stg[STAGES-1];
endmodule

// File: rtl/pp_seq_match.sv
module pp_seq_match
  import pp_wake_pkg::*;
#(
  parameter int DW = 8,
  parameter int CW = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DW-1:0]    byte_i,
  input  logic [CW-1:0]    ctl_i,
  output wake_st_e         st_o,
  output logic [IDX_W-1:0] idx_o,
  output logic [DW-1:0]    cmd_o,
  output logic             fire_o
);
  wake_st_e         st_q, st_d;
  logic [IDX_W-1:0] idx_q, idx_d, idx_rst;
  logic [DW-1:0]    prev_q, cmd_q, cmd_d;
  logic             chg, legal;

  assign chg     = (byte_i != prev_q);
  assign idx_rst = (byte_i == pat_byte('0)) ? IDX_W'(1) : '0;
  assign legal   = (byte_i == CMD_ON) || (byte_i == CMD_OFF) || (byte_i == CMD_PROBE);

  always_comb begin
    st_d   = st_q;
    idx_d  = idx_q;
    cmd_d  = cmd_q;
    fire_o = 1'b0;
    if (chg) begin
      // a data change always wins over a strobe in the same cycle
      if (st_q == ST_HUNT && idx_q == IDX_W'(PAT_LEN)) begin
        if (legal) begin
          st_d  = ST_ARMED;
          cmd_d = byte_i;
          idx_d = '0;
        end else begin
          idx_d = idx_rst;
        end
      end else if (st_q == ST_HUNT && byte_i == pat_byte(idx_q)) begin
        idx_d = idx_q + 1'b1;
      end else begin
        st_d  = ST_HUNT;
        idx_d = idx_rst;
      end
    end else begin
      case (st_q)
        ST_ARMED: if (ctl_i == CTL_STB) st_d = ST_STB;
        ST_STB: if (ctl_i == CTL_REST) begin
          fire_o = 1'b1;
          st_d   = ST_HUNT;
          idx_d  = '0;
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_HUNT;
      idx_q  <= '0;
      cmd_q  <= '0;
      prev_q <= '0;
    end else begin
      st_q   <= st_d;
      idx_q  <= idx_d;
      cmd_q  <= cmd_d;
      prev_q <= byte_i;
    end
  end

  assign st_o  = st_q;
  assign idx_o = idx_q;
  assign cmd_o = cmd_q;
endmodule

// File: rtl/pp_cmd_exec.sv
module pp_cmd_exec
  import pp_wake_pkg::*;
#(
  parameter int          DW      = 8,
  parameter logic [11:0] ID_CODE = 12'hB5F
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             fire_i,
  input  logic [DW-1:0]    cmd_i,
  input  wake_st_e         st_i,
  input  logic [IDX_W-1:0] idx_i,
  output logic             en_o,
  output logic             eng_rst_o,
  output logic [3:0]       nib_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_o      <= 1'b0;
      eng_rst_o <= 1'b0;
    end else begin
      eng_rst_o <= 1'b0;
      if (fire_i) begin
        case (cmd_i)
          CMD_ON: begin
            en_o      <= 1'b1;
            eng_rst_o <= 1'b1;
          end
          CMD_OFF:   en_o      <= 1'b0;
          CMD_PROBE: eng_rst_o <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    nib_o = '0;
    if (st_i == ST_STB)                                     nib_o = ID_CODE[3:0];
    else if (st_i == ST_HUNT && idx_i == IDX_W'(IDX_HI))  nib_o = ID_CODE[11:8];
    else if (st_i == ST_HUNT && idx_i == IDX_W'(IDX_MID)) nib_o = ID_CODE[7:4];
  end
endmodule

// File: rtl/pp_wake_detect.sv
module pp_wake_detect
  import pp_wake_pkg::*;
#(
  parameter int          DW          = 8,
  parameter int          CW          = 4,
  parameter int          SYNC_STAGES = 2,
  parameter logic [11:0] ID_CODE     = 12'hB5F
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [DW-1:0] pdata_i,
  input  logic [CW-1:0] pctl_i,
  output logic [3:0]    stat_o,
  output logic          enabled_o,
  output logic          eng_rst_o
);
  logic [DW-1:0]    data_s, cmd;
  logic [CW-1:0]    ctl_s;
  logic [IDX_W-1:0] idx;
  logic             fire;
  wake_st_e         st;

  pp_sync #(.W(DW), .STAGES(SYNC_STAGES)) i_sync_data (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pdata_i), .q_o(data_s)
  );

  pp_sync #(.W(CW), .STAGES(SYNC_STAGES)) i_sync_ctl (
    .clk_i(clk_i), .rst_ni(rst_ni), .d_i(pctl_i), .q_o(ctl_s)
  );

  pp_seq_match #(.DW(DW), .CW(CW)) i_match (
    .clk_i(clk_i), .rst_ni(rst_ni), .byte_i(data_s), .ctl_i(ctl_s),
    .st_o(st), .idx_o(idx), .cmd_o(cmd), .fire_o(fire)
  );

  pp_cmd_exec #(.DW(DW), .ID_CODE(ID_CODE)) i_exec (
    .clk_i(clk_i), .rst_ni(rst_ni), .fire_i(fire), .cmd_i(cmd),
    .st_i(st), .idx_i(idx), .en_o(enabled_o), .eng_rst_o(eng_rst_o),
    .nib_o(stat_o)
  );
endmodule

// File: rtl/pp_wake_chk.sv
module pp_wake_chk
  import pp_wake_pkg::*;
(
  input logic       clk_i,
  input logic       rst_ni,
  input wake_st_e   st_i,
  input logic       enabled_i,
  input logic       eng_rst_i,
  input logic [3:0] stat_i
);
  AST_PULSE_ONE_CYCLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eng_rst_i |=> !eng_rst_i); // R2
  AST_CONNECT_PULSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(enabled_i) |-> eng_rst_i); // R2
  AST_DISCONNECT_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(enabled_i) |-> !eng_rst_i); // R3
  AST_ACT_AFTER_STROBE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eng_rst_i || !$stable(enabled_i)) |-> $past(st_i) == ST_STB); // R5
  AST_STB_FROM_ARMED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_i == ST_STB && $past(st_i) != ST_STB) |-> $past(st_i) == ST_ARMED); // R5
  AST_ARMED_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_i == ST_ARMED |-> stat_i == 4'h0); // R6
endmodule

bind pp_wake_detect pp_wake_chk i_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .st_i(st), .enabled_i(enabled_o),
  .eng_rst_i(eng_rst_o), .stat_i(stat_o)
);

// File: tb/test_pp_wake_detect.sv
module test_pp_wake_detect;
  localparam int CLK_PERIOD = 10;
  localparam int NVEC = 11;
  // {data, ctl, exp_en, exp_stat}
  localparam logic [16:0] VEC [NVEC] = '{
    {8'hFE, 4'h4, 1'b0, 4'h0},
    {8'hAA, 4'h4, 1'b0, 4'h0},
    {8'h55, 4'h4, 1'b0, 4'h0},
    {8'h00, 4'h4, 1'b0, 4'h0},
    {8'hFF, 4'h4, 1'b0, 4'hB},
    {8'h87, 4'h4, 1'b0, 4'h5},
    {8'h78, 4'h4, 1'b0, 4'h0},
    {8'h20, 4'h4, 1'b0, 4'h0},
    {8'h20, 4'h5, 1'b0, 4'hF},
    {8'h20, 4'h4, 1'b1, 4'h0},
    {8'hFF, 4'h4, 1'b1, 4'h0}
  };

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] pdata = 8'h00;
  logic [3:0] pctl = 4'h4;
  logic [3:0] stat;
  logic       enabled, eng_rst;
  int         total = 0, bad = 0, pulses = 0;

  always #(CLK_PERIOD / 2) clk = ~clk;

  pp_wake_detect i_pp_wake_detect (
    .clk_i(clk), .rst_ni(rst_n), .pdata_i(pdata), .pctl_i(pctl),
    .stat_o(stat), .enabled_o(enabled), .eng_rst_o(eng_rst)
  );

  always @(negedge clk) if (eng_rst) pulses++;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic settle();
    repeat (4) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic put(input logic [7:0] d, input logic [3:0] c);
    pdata = d;
    pctl  = c;
    settle();
  endtask

  task automatic run_pat(input logic [7:0] cmd);
    put(8'hFE, 4'h4); put(8'hAA, 4'h4); put(8'h55, 4'h4); put(8'h00, 4'h4);
    put(8'hFF, 4'h4); put(8'h87, 4'h4); put(8'h78, 4'h4); put(cmd, 4'h4);
  endtask

  task automatic strobe();
    put(pdata, 4'h5);
    put(pdata, 4'h4);
    put(8'hFF, 4'h4);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 enabled", enabled, 0);
    chk("R1 status", stat, 0);
    chk("R1 pulses", pulses, 0);

    foreach (VEC[i]) begin
      put(VEC[i][16:9], VEC[i][8:5]);
      chk($sformatf("R2/R6 vec%0d enabled", i), enabled, VEC[i][4]);
      chk($sformatf("R6 vec%0d status", i), stat, VEC[i][3:0]);
    end
    chk("R2 one pulse", pulses, 1);

    run_pat(8'h00); strobe();
    chk("R4 enabled kept", enabled, 1);
    chk("R4 pulse", pulses, 2);

    run_pat(8'h30); strobe();
    chk("R3 enabled cleared", enabled, 0);
    chk("R3 no pulse", pulses, 2);

    run_pat(8'h20); put(8'hFF, 4'h4); put(8'hFF, 4'h5); put(8'hFF, 4'h4);
    chk("R5 no strobe enabled", enabled, 0);
    run_pat(8'h40); strobe();
    chk("R5 bad cmd enabled", enabled, 0);
    chk("R5 pulses", pulses, 2);

    put(8'hFE, 4'h4); put(8'hAA, 4'h4); put(8'h55, 4'h4); put(8'h13, 4'h4);
    put(8'h00, 4'h4); put(8'hFF, 4'h4);
    chk("R7 restart status", stat, 0);

    put(8'hFE, 4'h4); put(8'hAA, 4'h4); put(8'hFE, 4'h4); put(8'hAA, 4'h4);
    put(8'h55, 4'h4); put(8'h00, 4'h4); put(8'hFF, 4'h4);
    chk("R7 FE restart status", stat, 4'hB);
    put(8'h87, 4'h4); put(8'h78, 4'h4); put(8'h20, 4'h4); strobe();
    chk("R7 FE restart enabled", enabled, 1);
    chk("R7 pulse", pulses, 3);

    // R9: data change and strobe release in the same cycle
    run_pat(8'h30); put(8'h30, 4'h5);
    chk("R9 strobe status", stat, 4'hF);
    put(8'h11, 4'h4);
    chk("R9 abort enabled", enabled, 1);
    chk("R9 abort status", stat, 0);
    chk("R9 abort pulses", pulses, 3);

    put(8'hFE, 4'h4); put(8'hAA, 4'h4);
    repeat (20) @(posedge clk);
    @(negedge clk);
    put(8'h55, 4'h4); put(8'h00, 4'h4); put(8'hFF, 4'h4); put(8'h87, 4'h4);
    put(8'h78, 4'h4); put(8'h30, 4'h4); strobe();
    chk("R8 held byte", enabled, 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule